// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

This block decides, slot by slot, which internal serial channel owns each time slot of a TDM frame, and moves the slot bits accordingly. The receive and transmit directions each have their own route table. Each table is a list of runs. A run gives a number of consecutive slots, from 1 to 64, and the channel that owns them. Five channels are addressable. Code 0 means the slot belongs to no channel.

A separate bit-timing engine supplies three kinds of pulse for each direction: a frame-start pulse at the beginning of slot 0, a slot-advance pulse at each later 8-bit slot boundary, and a bit strobe for every data bit. On a frame start the sequencer goes back to the first run. On each slot advance it steps through the runs. In receive, the incoming bit strobe is steered to the owning channel. In transmit, the owning channel's bit is selected onto the line and that channel is told its bit was taken. A chip with two TDM links instantiates the block once per link, so each link has its own routing.

Tables are loaded through a one-cycle write port. Each write gives a direction, an entry index, the run length minus one, a channel code, a flags field and a last-entry marker.

Top module: `tdm_slot_router`

## Requirements
- R1: Reset empties both tables, so every slot is unused. Reset also clears the error flag, and no frame is walked until the next frame-start pulse.
- R2: A frame-start pulse restarts the walk at entry 0. Each entry then owns `len_m1+1` consecutive slots. Entries are applied in index order, and each slot-advance pulse moves the walk one slot forward.
- R3: In receive, while the slot owner is code k (1 to 5), a receive bit strobe raises only `rx_ch_stb[k-1]`. `rx_ch_bit` carries the line bit.
- R4: In transmit, while the slot owner is code k (1 to 5), `tx_out` equals `tx_ch_bit[k-1]`. A transmit bit strobe raises only `tx_ch_take[k-1]`.
- R5: In a slot with code 0, `tx_out` is 1, no `tx_ch_take` bit is raised and no `rx_ch_stb` bit is raised.
- R6: Once the run of the entry marked last is exhausted, the remaining slots are unused until the next frame start.
- R7: A frame-start pulse in the middle of a walk abandons the current position and begins again at slot 0.
- R8: A write whose channel code is above 5, or whose flags field is nonzero, sets `cfg_err`. The stored entry then has code 0. `cfg_err` stays set until reset.
- R9: Writes select their table with `wr_tx` (1 = transmit, 0 = receive). A write to one table never changes the other direction's routing.
- R10: Slot ownership changes only in the cycle after a frame-start or slot-advance pulse. It holds steady at all other times, including the cycle of the pulse itself.
- R11: A table holds 64 entries and a run may be 64 slots long. A 64-slot run and a table of 64 one-slot runs are both walked in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_tx | input | 1 | Table select, 1 = transmit, 0 = receive |
| wr_idx | input | 6 | Entry index |
| wr_len_m1 | input | 6 | Run length minus one |
| wr_dest | input | 3 | Channel code, 0 = unused, 1..5 = channel |
| wr_flags | input | 4 | Reserved, must be zero |
| wr_last | input | 1 | Entry ends the table |
| rx_fs | input | 1 | Receive frame start (slot 0 begins) |
| rx_adv | input | 1 | Receive slot boundary |
| rx_bit_stb | input | 1 | Receive bit valid |
| rx_bit | input | 1 | Receive line bit |
| rx_ch_stb | output | 5 | Per-channel receive bit strobe |
| rx_ch_bit | output | 1 | Receive bit to channels |
| tx_fs | input | 1 | Transmit frame start |
| tx_adv | input | 1 | Transmit slot boundary |
| tx_bit_stb | input | 1 | Transmit bit taken by line |
| tx_ch_bit | input | 5 | Per-channel transmit bit |
| tx_ch_take | output | 5 | Per-channel transmit bit taken |
| tx_out | output | 1 | Transmit line bit |
| cfg_err | output | 1 | Sticky bad-entry flag |

## Verification
Two tables with different run patterns are walked past their ends. The receive table has unused gaps inside it, and the transmit table has runs of one slot. This separates off-by-one errors in the run counter, errors in entry order, and failure to stop after the last entry. The transmit channel bits alternate between complementary patterns from slot to slot, so selecting the wrong channel shows up in the output. A restart in the middle of a frame, sampled both inside the pulse cycle and after it, checks the restart and the one-cycle latency. Bad-code and bad-flags writes are followed by walks of both directions, which checks that the bad entries are neutralised and that the other table is untouched. A 64-slot run and a full 64-entry table cover the size limits.

// File: rtl/tdm_route_pkg.sv
// Shared sizes and the stored route entry type for the TDM slot router.
package tdm_route_pkg;
    localparam int CH_N    = 5;                  // addressable serial channels
    localparam int MAX_ENT = 64;                 // entries per route table
    localparam int LEN_W   = 6;                  // run length minus one, 1..64 slots
    localparam int IDX_W   = $clog2(MAX_ENT);
    localparam int DEST_W  = $clog2(CH_N + 1);   // 0 = unused, 1..CH_N = channel

    typedef struct packed {
        logic              last;
        logic [DEST_W-1:0] dest;
        logic [LEN_W-1:0]  len_m1;
    } route_ent_t;
endpackage

// File: rtl/tdm_route_table.sv
// One route table: MAX_ENT flop entries, one write port and one combinational
// read port. A bad write is stored with code 0 and reported through bad_wr.
// Assumes: reset leaves a single empty last entry, so an unprogrammed table
// routes nothing.
module tdm_route_table
    import tdm_route_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [LEN_W-1:0]  wlen_m1,
    input  logic [DEST_W-1:0] wdest,
    input  logic [FLAG_W-1:0] wflags,
    input  logic              wlast,
    input  logic [IDX_W-1:0]  ridx,
    output route_ent_t        rent,
    output logic              bad_wr
);
    localparam route_ent_t EMPTY_ENT = '{last: 1'b1, dest: '0, len_m1: '0};

    route_ent_t tbl_q [MAX_ENT];
    route_ent_t clean;
    logic       bad;

    // Sanitise the incoming entry: bad code or nonzero flags make it unused.
    always_comb begin
        bad          = (wdest > DEST_W'(CH_N)) || (wflags != '0);
        clean.last   = wlast;
        clean.len_m1 = wlen_m1;
        clean.dest   = bad ? '0 : wdest;
    end

    // Table storage with reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_ENT; i++) tbl_q[i] <= EMPTY_ENT;
        end else if (we) begin
            tbl_q[widx] <= clean;
        end
    end

    // Combinational read and error report.
    assign rent   = tbl_q[ridx];
    assign bad_wr = we && bad;
endmodule

// File: rtl/tdm_slot_walker.sv
// Walks one route table across a frame. A frame start loads entry 0. Each slot
// boundary counts down the current run and then moves to the next entry. After
// the last entry, or the final index, the owner stays 0 until the next frame start.
// Assumes: boundary pulses are one cycle wide, and owner is valid from the cycle after.
module tdm_slot_walker
    import tdm_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic              adv,
    output logic [IDX_W-1:0]  rd_idx,
    input  route_ent_t        rd_ent,
    output logic [DEST_W-1:0] owner
);
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  rem_q;
    logic [DEST_W-1:0] dest_q;
    logic              last_q;
    logic              active_q;
    logic              at_end;

    // Address of the entry needed at the coming boundary.
    always_comb rd_idx = fs ? '0 : idx_q + 1'b1;

    // Stop after the marked last entry or at the last physical index.
    always_comb at_end = last_q || (idx_q == IDX_W'(MAX_ENT - 1));

    // Walk state: run countdown and entry stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            rem_q    <= '0;
            dest_q   <= '0;
            last_q   <= 1'b0;
            active_q <= 1'b0;
        end else if (fs) begin
            idx_q    <= '0;
            rem_q    <= rd_ent.len_m1;
            dest_q   <= rd_ent.dest;
            last_q   <= rd_ent.last;
            active_q <= 1'b1;
        end else if (adv && active_q) begin
            if (rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end else if (at_end) begin
                active_q <= 1'b0;
                dest_q   <= '0;
            end else begin
                idx_q  <= rd_idx;
                rem_q  <= rd_ent.len_m1;
                dest_q <= rd_ent.dest;
                last_q <= rd_ent.last;
            end
        end
    end

    assign owner = dest_q;
endmodule

// File: rtl/tdm_slot_router.sv
// Top: receive and transmit route tables with their walkers, receive bit
// steering, transmit bit selection and the sticky bad-entry flag.
// Assumes: the timing engine gives frame start, slot boundary and bit strobes
// as one-cycle pulses, and bit strobes fall outside boundary cycles.
module tdm_slot_router
    import tdm_route_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LEN_W-1:0]  wr_len_m1,
    input  logic [DEST_W-1:0] wr_dest,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              wr_last,
    input  logic              rx_fs,
    input  logic              rx_adv,
    input  logic              rx_bit_stb,
    input  logic              rx_bit,
    output logic [CH_N-1:0]   rx_ch_stb,
    output logic              rx_ch_bit,
    input  logic              tx_fs,
    input  logic              tx_adv,
    input  logic              tx_bit_stb,
    input  logic [CH_N-1:0]   tx_ch_bit,
    output logic [CH_N-1:0]   tx_ch_take,
    output logic              tx_out,
    output logic              cfg_err
);
    localparam int DIR_N = 2;   // index 0 = receive, 1 = transmit

    logic              fs_v    [DIR_N];
    logic              adv_v   [DIR_N];
    logic              bad_v   [DIR_N];
    logic [IDX_W-1:0]  ridx_v  [DIR_N];
    route_ent_t        ent_v   [DIR_N];
    logic [DEST_W-1:0] owner_v [DIR_N];
    logic [DEST_W-1:0] rx_owner;
    logic [DEST_W-1:0] tx_owner;
    logic              err_q;

    assign fs_v[0]  = rx_fs;
    assign fs_v[1]  = tx_fs;
    assign adv_v[0] = rx_adv;
    assign adv_v[1] = tx_adv;

    // One table and one walker per direction.
    for (genvar d = 0; d < DIR_N; d++) begin : g_dir
        tdm_route_table #(.FLAG_W(FLAG_W)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (wr_tx == 1'(d))),
            .widx    (wr_idx),
            .wlen_m1 (wr_len_m1),
            .wdest   (wr_dest),
            .wflags  (wr_flags),
            .wlast   (wr_last),
            .ridx    (ridx_v[d]),
            .rent    (ent_v[d]),
            .bad_wr  (bad_v[d])
        );
        tdm_slot_walker u_walk (
            .clk    (clk),
            .rst_n  (rst_n),
            .fs     (fs_v[d]),
            .adv    (adv_v[d]),
            .rd_idx (ridx_v[d]),
            .rd_ent (ent_v[d]),
            .owner  (owner_v[d])
        );
    end

    assign rx_owner = owner_v[0];
    assign tx_owner = owner_v[1];

    // Per-channel strobes decoded from the slot owners.
    for (genvar k = 0; k < CH_N; k++) begin : g_ch
        assign rx_ch_stb[k]  = rx_bit_stb && (rx_owner == DEST_W'(k + 1));
        assign tx_ch_take[k] = tx_bit_stb && (tx_owner == DEST_W'(k + 1));
    end

    assign rx_ch_bit = rx_bit;

    // Transmit line bit: owning channel's bit, or idle 1 in unused slots.
    always_comb begin
        tx_out = 1'b1;
        for (int k = 0; k < CH_N; k++) begin
            if (tx_owner == DEST_W'(k + 1)) tx_out = tx_ch_bit[k];
        end
    end

    // Sticky error for bad writes to either table.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (bad_v[0] || bad_v[1]) err_q <= 1'b1;
    end

    assign cfg_err = err_q;
endmodule

// File: rtl/tdm_route_chk.sv
// Checker for tdm_slot_router: port relations and owner timing.
module tdm_route_chk
    import tdm_route_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_fs,
    input logic              rx_adv,
    input logic              tx_fs,
    input logic              tx_adv,
    input logic              rx_bit_stb,
    input logic              tx_bit_stb,
    input logic [CH_N-1:0]   rx_ch_stb,
    input logic [CH_N-1:0]   tx_ch_take,
    input logic [CH_N-1:0]   tx_ch_bit,
    input logic              tx_out,
    input logic              cfg_err,
    input logic [DEST_W-1:0] rx_owner,
    input logic [DEST_W-1:0] tx_owner
);
    p_clear_r1: assert property (@(posedge clk) !rst_n |=> (!cfg_err && rx_owner == '0 && tx_owner == '0));
    p_rx_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rx_ch_stb));
    p_rx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n) !rx_bit_stb |-> (rx_ch_stb == '0));
    p_tx_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_ch_take));
    p_tx_data_r4: assert property (@(posedge clk) disable iff (!rst_n) (tx_ch_take != '0) |-> (tx_out == |(tx_ch_take & tx_ch_bit)));
    p_tx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n) (tx_bit_stb && tx_ch_take == '0) |-> tx_out);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err);
    p_owner_range_r8: assert property (@(posedge clk) disable iff (!rst_n) (rx_owner <= DEST_W'(CH_N)) && (tx_owner <= DEST_W'(CH_N)));
    p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) (!rx_fs && !rx_adv) |=> $stable(rx_owner));
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) (!tx_fs && !tx_adv) |=> $stable(tx_owner));
endmodule

bind tdm_slot_router tdm_route_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_fs      (rx_fs),
    .rx_adv     (rx_adv),
    .tx_fs      (tx_fs),
    .tx_adv     (tx_adv),
    .rx_bit_stb (rx_bit_stb),
    .tx_bit_stb (tx_bit_stb),
    .rx_ch_stb  (rx_ch_stb),
    .tx_ch_take (tx_ch_take),
    .tx_ch_bit  (tx_ch_bit),
    .tx_out     (tx_out),
    .cfg_err    (cfg_err),
    .rx_owner   (rx_owner),
    .tx_owner   (tx_owner)
);

// File: tb/tb_tdm_slot_router.sv
module tb_tdm_slot_router;
    import tdm_route_pkg::*;

    localparam int CLK_NS = 10;
    localparam int RX_N = 4;
    localparam int TX_N = 5;
    // Vectors: {len_m1[5:0], dest[2:0]}
    localparam logic [8:0] RXV [RX_N] = '{ {6'd1, 3'd0}, {6'd23, 3'd3}, {6'd0, 3'd0}, {6'd4, 3'd2} };
    localparam logic [8:0] TXV [TX_N] = '{ {6'd0, 3'd1}, {6'd2, 3'd4}, {6'd1, 3'd5}, {6'd3, 3'd0}, {6'd2, 3'd2} };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_tx = 1'b0, wr_last = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [LEN_W-1:0] wr_len_m1 = '0;
    logic [DEST_W-1:0] wr_dest = '0;
    logic [3:0] wr_flags = '0;
    logic rx_fs = 1'b0, rx_adv = 1'b0, rx_bit_stb = 1'b0, rx_bit = 1'b0;
    logic tx_fs = 1'b0, tx_adv = 1'b0, tx_bit_stb = 1'b0;
    logic [CH_N-1:0] tx_ch_bit = '0;
    logic [CH_N-1:0] rx_ch_stb, tx_ch_take;
    logic rx_ch_bit, tx_out, cfg_err;

    int total = 0;
    int bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    tdm_slot_router dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tx(wr_tx), .wr_idx(wr_idx),
        .wr_len_m1(wr_len_m1), .wr_dest(wr_dest), .wr_flags(wr_flags), .wr_last(wr_last),
        .rx_fs(rx_fs), .rx_adv(rx_adv), .rx_bit_stb(rx_bit_stb), .rx_bit(rx_bit),
        .rx_ch_stb(rx_ch_stb), .rx_ch_bit(rx_ch_bit), .tx_fs(tx_fs), .tx_adv(tx_adv),
        .tx_bit_stb(tx_bit_stb), .tx_ch_bit(tx_ch_bit), .tx_ch_take(tx_ch_take),
        .tx_out(tx_out), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int oh(input int c);
        return (c == 0) ? 0 : (1 << (c - 1));
    endfunction

    // Expected owner of a slot from the vector tables; kill masks receive entries.
    function automatic int vec_owner(input bit tx, input int slot, input int kill);
        int base = 0;
        int n = tx ? TX_N : RX_N;
        for (int i = 0; i < n; i++) begin
            logic [8:0] v = tx ? TXV[i] : RXV[i];
            int cnt = int'(v[8:3]) + 1;
            if (slot >= base && slot < base + cnt)
                return (!tx && kill[i]) ? 0 : int'(v[2:0]);
            base += cnt;
        end
        return 0;
    endfunction

    task automatic wr(input bit tx, input int idx, input int len_m1, input int dest, input int flags, input bit last);
        @(negedge clk);
        wr_en = 1'b1; wr_tx = tx; wr_idx = IDX_W'(idx); wr_len_m1 = LEN_W'(len_m1);
        wr_dest = DEST_W'(dest); wr_flags = 4'(flags); wr_last = last;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Boundary pulse on both directions: frame start or slot advance.
    task automatic step(input bit fs);
        @(negedge clk);
        rx_fs = fs; tx_fs = fs; rx_adv = !fs; tx_adv = !fs;
        @(negedge clk);
        rx_fs = 1'b0; tx_fs = 1'b0; rx_adv = 1'b0; tx_adv = 1'b0;
    endtask

    // Assert bit strobes with a slot-dependent pattern and check both directions.
    task automatic look(input int rx_exp, input int tx_exp, input int s, input string tag);
        logic [CH_N-1:0] pat;
        int txb;
        pat = (s % 2 == 1) ? 5'b10110 : 5'b01001;
        tx_ch_bit = pat; rx_bit_stb = 1'b1; tx_bit_stb = 1'b1; rx_bit = s[0];
        #1;
        txb = (tx_exp == 0) ? 1 : int'(pat[tx_exp - 1]);
        chk(rx_ch_stb == CH_N'(oh(rx_exp)), {tag, (rx_exp == 0) ? " R5 rx" : " R3 rx"}, int'(rx_ch_stb), oh(rx_exp));
        chk(tx_ch_take == CH_N'(oh(tx_exp)) && tx_out == txb[0],
            {tag, (tx_exp == 0) ? " R5 tx" : " R4 tx"}, int'({tx_ch_take, tx_out}), (oh(tx_exp) << 1) | txb);
        chk(rx_ch_bit == s[0], {tag, " R3 rxbit"}, int'(rx_ch_bit), s & 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_vectors();
        for (int i = 0; i < RX_N; i++) wr(1'b0, i, int'(RXV[i][8:3]), int'(RXV[i][2:0]), 0, i == RX_N - 1);
        for (int i = 0; i < TX_N; i++) wr(1'b1, i, int'(TXV[i][8:3]), int'(TXV[i][2:0]), 0, i == TX_N - 1);
    endtask

    task automatic walk_vectors(input int kill, input string tag);
        for (int s = 0; s < 36; s++) begin
            step(s == 0);
            look(vec_owner(1'b0, s, kill), vec_owner(1'b1, s, 0), s, (s >= 32) ? {tag, " R6"} : {tag, " R2"});
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then a frame on empty tables
        #1;
        chk(cfg_err == 1'b0, "R1 err after reset", int'(cfg_err), 0);
        look(0, 0, 0, "R1 before frame");
        step(1'b1);
        look(0, 0, 1, "R1 empty table");

        // Vector table walk: R2 R3 R4 R5 R6
        load_vectors();
        walk_vectors(0, "vec");

        // R7 R10: restart mid-frame while in slot 5 (rx ch3, tx ch5)
        step(1'b1);
        for (int s = 1; s <= 5; s++) step(1'b0);
        @(negedge clk);
        rx_fs = 1'b1; tx_fs = 1'b1;
        look(3, 5, 5, "R10 owner held in pulse cycle");
        @(negedge clk);
        rx_fs = 1'b0; tx_fs = 1'b0;
        look(0, 1, 0, "R7 restart at slot 0");
        step(1'b0);
        look(0, 4, 1, "R7 slot 1 after restart");

        // R8 R9: bad code and bad flags neutralise receive entries only
        wr(1'b0, 1, 23, 6, 0, 1'b0);
        #1;
        chk(cfg_err == 1'b1, "R8 err on bad code", int'(cfg_err), 1);
        wr(1'b0, 3, 4, 2, 1, 1'b1);
        wr(1'b1, 0, 0, 1, 0, 1'b0);
        #1;
        chk(cfg_err == 1'b1, "R8 err sticky", int'(cfg_err), 1);
        walk_vectors(5'b01010, "R8 R9 bad");

        // R1: reset clears error and tables
        do_reset();
        #1;
        chk(cfg_err == 1'b0, "R1 err cleared", int'(cfg_err), 0);
        step(1'b1);
        look(0, 0, 0, "R1 tables cleared");

        // R11: 64-slot tx run, 64-entry rx table
        wr(1'b1, 0, 63, 5, 0, 1'b1);
        for (int i = 0; i < 64; i++) wr(1'b0, i, 0, (i % 5) + 1, 0, i == 63);
        for (int s = 0; s < 66; s++) begin
            step(s == 0);
            look((s < 64) ? (s % 5) + 1 : 0, (s < 64) ? 5 : 0, s, (s < 64) ? "R11 full" : "R11 R6 past end");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule